// File: doc/BRIEF.md
# Prescaled Tick Timer With Compare Alarm

This block is a real-time tick source for a processor running a timing kernel. A prescaler up-counter divides the core clock by a programmable ratio. Each time the prescaler reaches its programmed limit it returns to zero and advances a free-running tick counter by one. A compare unit watches the tick counter and raises an alarm flag when the counter steps onto the programmed compare value. The flag drives an interrupt line when its enable is set.

Software controls the block through a simple word-addressed register port. Writes take effect on the next clock edge and reads return the current value in the same cycle. Software stops the counter pair, loads the divide ratio minus one, restarts both counters from zero and then runs them again. It binds the compare unit to the tick counter and sets the alarm enable. To arm an alarm, it clears the flag and writes an absolute tick value into the compare register. The flag stays set until software writes a one to it. Software can therefore tell that an alarm has already fired, even when the alarm came while it was reprogramming the compare value.

Top module: `tick_alarm_timer`

## Requirements
- R1: Bit 1 of the control register (address 0) is the run bit. While it is 0, the prescaler and the tick counter both hold their values. The reset value of the run bit is 0.
- R2: The prescaler limit register (address 1) holds the divide ratio minus one. While running, the tick counter advances once every limit+1 clock cycles. With both counters starting at zero, the tick counter reads floor(K/(limit+1)) after K running cycles.
- R3: The prescaler (address 2) and the tick counter (address 3) can be written directly. A write in a cycle replaces the value that counting would have produced in that cycle.
- R4: The tick counter is 32 bits wide and wraps from 0xFFFFFFFF to 0. An alarm at compare value 0 fires on that wrap.
- R5: The alarm flag is bit 3 of the flag register (address 7). Writing 1 to that bit clears the flag, and writing 0 leaves it unchanged. If a clearing write and an alarm fall on the same cycle, the flag ends up set.
- R6: Bit 12 of the compare select register (address 4) binds the compare unit to the tick counter. While that bit is 0, the flag never sets.
- R7: The flag sets only on a counting step that moves the tick counter onto the compare value (address 5). Writing a compare value that equals or lies behind the counter does not set the flag.
- R8: Writing 1 to bit 3 of the enable-set register (address 6) enables the alarm. Reads of address 6 return that enable at bit 3. The interrupt output is high exactly when both the flag and the enable are set.
- R9: Reads are combinational from the address. After reset, every register reads 0 and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The bench sweeps divide ratios from 1 to 5 over two run lengths. A prescaler that counts one cycle too many or too few gives the wrong tick count for at least one pair in the sweep. The bench looks for a flag that fires on equality alone: it writes a compare value the counter already holds while the counter is stopped, and it sets a value the counter has already passed. It also runs with the compare unit unbound. An equality-only design would raise a false alarm in these cases. A clearing write is placed on the exact cycle of an alarm, so a design that lets the clear win would lose that alarm. An alarm placed on the 32-bit wrap checks that the counter does not saturate and that the compare does not ignore zero.

// File: rtl/tat_pkg.sv
package tat_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL  = 3'd0,
    RA_LIMIT = 3'd1,
    RA_PRE   = 3'd2,
    RA_TICKS = 3'd3,
    RA_CSEL  = 3'd4,
    RA_CVAL  = 3'd5,
    RA_IENS  = 3'd6,
    RA_IFLG  = 3'd7
  } reg_addr_e;

  localparam int RUN_BIT   = 1;
  localparam int ALARM_BIT = 3;
  localparam int BIND_BIT  = 12;
endpackage

// File: rtl/tat_prescaler.sv
module tat_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         tick
);
  function automatic logic [W-1:0] pre_next(input logic [W-1:0] c, input logic at_lim);
    return at_lim ? '0 : c + W'(1);
  endfunction

  assign tick = run && !wr && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (wr)  cnt <= wdata;
    else if (run) cnt <= pre_next(cnt, cnt == limit);
  end
endmodule

// File: rtl/tat_counter.sv
module tat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         step
);
  function automatic logic [W-1:0] wrap_inc(input logic [W-1:0] c);
    return c + W'(1);
  endfunction

  assign step    = tick && !wr;
  assign cnt_nxt = wrap_inc(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (wr)   cnt <= wdata;
    else if (step) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/tat_compare.sv
module tat_compare #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bound,
  input  logic         step,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] cval,
  input  logic         clr,
  output logic         hit,
  output logic         flag
);
  assign hit = bound && step && (cnt_nxt == cval);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/tick_alarm_timer.sv
module tick_alarm_timer
  import tat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [REG_AW-1:0]   bus_addr,
  input  logic [CNT_W-1:0]    bus_wdata,
  output logic [CNT_W-1:0]    bus_rdata,
  output logic                alarm_irq
);
  logic             run_q;
  logic             bind_q;
  logic             en_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] cval_q;
  logic [CNT_W-1:0] pre_cnt;
  logic [CNT_W-1:0] tick_cnt;
  logic [CNT_W-1:0] tick_nxt;
  logic             tick_evt;
  logic             step_evt;
  logic             hit_evt;
  logic             alarm_flag;

  logic wr_ctrl, wr_limit, wr_pre, wr_ticks, wr_csel, wr_cval, wr_iens, wr_iflg;
  logic flag_clr;

  assign wr_ctrl  = bus_wr && (bus_addr == RA_CTRL);
  assign wr_limit = bus_wr && (bus_addr == RA_LIMIT);
  assign wr_pre   = bus_wr && (bus_addr == RA_PRE);
  assign wr_ticks = bus_wr && (bus_addr == RA_TICKS);
  assign wr_csel  = bus_wr && (bus_addr == RA_CSEL);
  assign wr_cval  = bus_wr && (bus_addr == RA_CVAL);
  assign wr_iens  = bus_wr && (bus_addr == RA_IENS);
  assign wr_iflg  = bus_wr && (bus_addr == RA_IFLG);
  assign flag_clr = wr_iflg && bus_wdata[ALARM_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      bind_q  <= 1'b0;
      en_q    <= 1'b0;
      limit_q <= '0;
      cval_q  <= '0;
    end else begin
      if (wr_ctrl)  run_q   <= bus_wdata[RUN_BIT];
      if (wr_csel)  bind_q  <= bus_wdata[BIND_BIT];
      if (wr_iens && bus_wdata[ALARM_BIT]) en_q <= 1'b1;
      if (wr_limit) limit_q <= bus_wdata;
      if (wr_cval)  cval_q  <= bus_wdata;
    end
  end

  tat_prescaler #(.W(CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .wr(wr_pre), .wdata(bus_wdata),
    .limit(limit_q), .cnt(pre_cnt), .tick(tick_evt)
  );

  tat_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_evt), .wr(wr_ticks), .wdata(bus_wdata),
    .cnt(tick_cnt), .cnt_nxt(tick_nxt), .step(step_evt)
  );

  tat_compare #(.W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .bound(bind_q), .step(step_evt), .cnt_nxt(tick_nxt),
    .cval(cval_q), .clr(flag_clr), .hit(hit_evt), .flag(alarm_flag)
  );

  assign alarm_irq = alarm_flag && en_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_CTRL:  bus_rdata[RUN_BIT]   = run_q;
      RA_LIMIT: bus_rdata            = limit_q;
      RA_PRE:   bus_rdata            = pre_cnt;
      RA_TICKS: bus_rdata            = tick_cnt;
      RA_CSEL:  bus_rdata[BIND_BIT]  = bind_q;
      RA_CVAL:  bus_rdata            = cval_q;
      RA_IENS:  bus_rdata[ALARM_BIT] = en_q;
      RA_IFLG:  bus_rdata[ALARM_BIT] = alarm_flag;
      default:  bus_rdata            = '0;
    endcase
  end
endmodule

// File: rtl/tat_checker.sv
module tat_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         tick,
  input logic         pre_wr,
  input logic         cnt_wr,
  input logic [W-1:0] pre_cnt,
  input logic [W-1:0] limit,
  input logic [W-1:0] count,
  input logic [W-1:0] cval,
  input logic         bound,
  input logic         clr,
  input logic         hit,
  input logic         flag,
  input logic         en,
  input logic         irq
);
  // R1: stopped counters hold
  p_hold_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !pre_wr && !cnt_wr) |=> ($stable(count) && $stable(pre_cnt)));

  // R2: a tick happens only with the prescaler at its limit while running
  p_tick_at_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (run && pre_cnt == limit));

  // R2: prescaler returns to zero after a tick
  p_pre_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pre_wr) |=> (pre_cnt == '0));

  // R4: counter steps by one, modulo 2^W
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> (count == $past(count) + W'(1)));

  // R7: a rising flag follows a counting step onto the compare value
  p_flag_on_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(tick && !cnt_wr && bound) && count == $past(cval)));

  // R6: unbound compare never raises the flag
  p_unbound_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bound && !flag) |=> !flag);

  // R5: a clear without a coinciding alarm drops the flag
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);

  // R8: no interrupt without its enable
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || !flag) |-> !irq);
endmodule

bind tick_alarm_timer tat_checker #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick_evt), .pre_wr(wr_pre),
  .cnt_wr(wr_ticks), .pre_cnt(pre_cnt), .limit(limit_q), .count(tick_cnt),
  .cval(cval_q), .bound(bind_q), .clr(flag_clr), .hit(hit_evt),
  .flag(alarm_flag), .en(en_q), .irq(alarm_irq)
);

// File: tb/tick_alarm_timer_tb.sv
module tick_alarm_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam logic [2:0] A_CTRL = 3'd0, A_LIM = 3'd1, A_PRE = 3'd2, A_TCK = 3'd3,
                         A_SEL = 3'd4, A_CMP = 3'd5, A_IEN = 3'd6, A_FLG = 3'd7;
  localparam logic [W-1:0] RUN = 32'h2, BIND = 32'h1000, ABIT = 32'h8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         alarm_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  tick_alarm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic restart(input logic [W-1:0] cnt0, input logic [W-1:0] lim);
    wr(A_CTRL, 32'h0);
    wr(A_TCK, cnt0);
    wr(A_PRE, 32'h0);
    wr(A_LIM, lim);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v, c1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset values
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      check("R9 reset reg", v, '0);
    end
    check("R9 reset irq", {31'b0, alarm_irq}, 32'h0);

    // R2 / R1: divide sweep
    for (int n = 0; n < 5; n++) begin
      for (int ki = 0; ki < 2; ki++) begin
        int k;
        k = (ki == 0) ? 7 : 13;
        restart(32'h0, n[W-1:0]);
        wr(A_CTRL, RUN);
        wait_cyc(k);
        rd(A_TCK, v);
        check("R2 tick count", v, W'(k / (n + 1)));
        wr(A_CTRL, 32'h0);
        rd(A_TCK, c1);
        wait_cyc(5);
        rd(A_TCK, v);
        check("R1 hold when stopped", v, c1);
      end
    end

    // R3: direct writes
    wr(A_PRE, 32'h3);
    rd(A_PRE, v);
    check("R3 prescaler write", v, 32'h3);
    wr(A_TCK, 32'h1234);
    rd(A_TCK, v);
    check("R3 counter write", v, 32'h1234);

    // R6/R7/R8: alarm with enable off
    restart(32'h0, 32'h1);
    wr(A_CMP, 32'h5);
    wr(A_SEL, BIND);
    rd(A_SEL, v);
    check("R6 bind readback", v, BIND);
    wr(A_CTRL, RUN);
    wait_cyc(9);
    rd(A_FLG, v);
    check("R7 no flag before hit", v, 32'h0);
    wait_cyc(1);
    rd(A_FLG, v);
    check("R7 flag on hit", v, ABIT);
    check("R8 irq masked", {31'b0, alarm_irq}, 32'h0);
    wr(A_IEN, ABIT);
    check("R8 irq enabled", {31'b0, alarm_irq}, 32'h1);
    rd(A_IEN, v);
    check("R8 enable readback", v, ABIT);

    // R5: write zero ignored, write one clears
    wr(A_FLG, 32'h0);
    rd(A_FLG, v);
    check("R5 write zero ignored", v, ABIT);
    wr(A_FLG, ABIT);
    rd(A_FLG, v);
    check("R5 clear", v, 32'h0);
    check("R5 irq after clear", {31'b0, alarm_irq}, 32'h0);

    // R7: compare written to present and past values
    wr(A_CTRL, 32'h0);
    rd(A_TCK, c1);
    wr(A_CMP, c1);
    wait_cyc(3);
    rd(A_FLG, v);
    check("R7 equal value written", v, 32'h0);
    wr(A_CMP, c1 - 32'h1);
    wr(A_CTRL, RUN);
    wait_cyc(4);
    rd(A_FLG, v);
    check("R7 passed value", v, 32'h0);

    // R6: unbound
    restart(32'h0, 32'h0);
    wr(A_SEL, 32'h0);
    wr(A_CMP, 32'h3);
    wr(A_CTRL, RUN);
    wait_cyc(6);
    rd(A_TCK, v);
    check("R6 unbound count", v, 32'h6);
    rd(A_FLG, v);
    check("R6 unbound no flag", v, 32'h0);

    // R4: wrap
    restart(32'hFFFF_FFFE, 32'h0);
    wr(A_SEL, BIND);
    wr(A_CMP, 32'h0);
    wr(A_CTRL, RUN);
    wait_cyc(2);
    rd(A_TCK, v);
    check("R4 wrap to zero", v, 32'h0);
    rd(A_FLG, v);
    check("R4 alarm at wrap", v, ABIT);
    wait_cyc(1);
    rd(A_TCK, v);
    check("R4 after wrap", v, 32'h1);
    wr(A_FLG, ABIT);

    // R5: alarm wins over coinciding clear
    restart(32'd100, 32'h0);
    wr(A_CMP, 32'd103);
    wr(A_FLG, ABIT);
    wr(A_CTRL, RUN);
    wait_cyc(2);
    wr(A_FLG, ABIT);
    rd(A_TCK, v);
    check("R5 counter at hit", v, 32'd103);
    rd(A_FLG, v);
    check("R5 set beats clear", v, ABIT);
    check("R8 irq on", {31'b0, alarm_irq}, 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule